// File: doc/BRIEF.md
# 16-bit PC Card Socket Cycle Generator

This block converts a single host access request into the strobe sequence that a 16-bit PC Card expects at its socket. A request names the direction (read or write), the space (memory or I/O), attribute versus common memory, a 26-bit card address, two byte enables and a write word. The block drives the two card enables, the register-select line, the memory output-enable and write-enable strobes, and the I/O read and I/O write strobes. It drives the 16-bit card data bus on writes and samples it on reads. When the access completes it returns a one-clock done pulse together with the assembled read word.

Each access has three phases: setup, command and hold. The host sets the length of each phase in host clocks, and a typical setting is 2, 6 and 2. The card can stretch the command phase with its wait input. The socket runs in either 16-bit or 8-bit mode, and the mode sets how bytes are steered onto the card enables and data lanes. A word access is split into two byte accesses when the socket is in 8-bit mode. It is also split when an I/O port reports through its size input that it is only 8 bits wide. The block accepts a new request only while it is not busy.

Top module: `pcc16_cycle_gen`

## Requirements
- R1: While no access is in progress (busy low), every strobe, both card enables and register-select are high, the data bus is not driven (data_oe low, data_out 0) and card_addr is 0.
- R2: Through setup, command and hold, register-select is low for every I/O access. For a memory access it is low when attribute space is requested and high when common space is requested.
- R3: Output enable goes low only in the command phase of a memory read, and write enable goes low only in the command phase of a memory write. At most one of the four command strobes is low at any time.
- R4: The I/O read strobe goes low only in the command phase of an I/O read, and the I/O write strobe goes low only in the command phase of an I/O write.
- R5: In 16-bit socket mode, byte enables 2'b11 drive both card enables low with address bit 0 at 0. Byte enables 2'b01 drive card enable 1 alone with address bit 0 at 0, and the byte uses data bits 7:0. Byte enables 2'b10 drive card enable 2 alone with address bit 0 at 1, and the byte uses data bits 15:8.
- R6: In 8-bit socket mode, card enable 2 stays high and card enable 1 alone is used. Address bit 0 selects the byte (0 even, 1 odd), and the byte travels on data bits 7:0. A word request (byte enables 2'b11) runs as an even-byte access followed by an odd-byte access.
- R7: Setup, command and hold last the programmed number of clocks, and a programmed 0 counts as 1. The lengths are captured when a request is accepted. Without wait, an access of P byte/word parts keeps busy high for P*(setup+command+hold)+1 clocks.
- R8: The wait input (active low) passes through a two-flop synchroniser. It is consulted only on the last clock of the minimum command width. Each clock on which the synchronised wait is active holds the strobe low for one more clock.
- R9: For an I/O word access in 16-bit socket mode, the size input (low means a 16-bit port) is sampled on the last setup clock. If it is high, the access continues as an even-byte 8-bit-style part (card enable 1 only, A0=0, data bits 7:0) and then an odd-byte part (A0=1, data bits 7:0).
- R10: Done is high for exactly one clock, the clock after the last hold clock. Read data is captured on the last command clock of each part. The returned word has the even byte in bits 7:0 and the odd byte in bits 15:8, and any byte that was not read is 0.
- R11: On writes the data bus is driven from setup through hold. 16-bit-mode parts drive the request word unchanged. 8-bit-style parts drive the selected byte on bits 7:0 with bits 15:8 at 0. Reads never drive the bus.
- R12: A request presented while busy is high is ignored and does not change the access in progress.
- R13: Byte enables 2'b00 select a single byte whose lane is chosen by request address bit 0, as if only that byte's enable were set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken only when busy is low |
| req_write | input | 1 | 1 write, 0 read |
| req_io | input | 1 | 1 I/O space, 0 memory space |
| req_attr | input | 1 | 1 attribute memory, 0 common memory |
| req_addr | input | 26 | Card address |
| req_be | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| req_wdata | input | 16 | Write word |
| cfg_bus16 | input | 1 | 1 socket in 16-bit mode, 0 in 8-bit mode |
| cfg_setup | input | 4 | Setup length in clocks |
| cfg_cmd | input | 4 | Minimum command length in clocks |
| cfg_hold | input | 4 | Hold length in clocks |
| card_wait_n | input | 1 | Card wait request, active low |
| card_iois16_n | input | 1 | Card I/O port size, low for 16-bit |
| card_data_in | input | 16 | Data sampled from the card |
| card_ce1_n | output | 1 | Card enable for even bytes |
| card_ce2_n | output | 1 | Card enable for odd bytes |
| card_reg_n | output | 1 | Register-select, attribute/I-O when low |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_addr | output | 26 | Address to the card |
| card_data_out | output | 16 | Data to the card |
| card_data_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read word, valid with done |

## Verification
All socket outputs are Moore outputs of the phase register. Setup therefore appears on the first clock after the accepting edge, and each phase boundary becomes visible one clock after the counter reaches zero. The bench's behavioural model advances at the same edge as the design and compares every output half a clock later, on every clock. Wait changes reach the phase logic two edges after the pin moves, so the model runs its own two-stage pipeline. Done and the read word are checked on the clock after the last hold clock against values worked out per scenario, and the busy length is counted against P*(S+C+H)+1.

// File: rtl/pcc16_pkg.sv
package pcc16_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CMD,
        PH_HOLD,
        PH_DONE
    } phase_e;

    // Lane plan of one byte/word part of an access.
    typedef enum logic [2:0] {
        LK_WORD,    // both enables, 16-bit lanes
        LK_EVEN16,  // enable 1, low lane
        LK_ODD16,   // enable 2, high lane
        LK_EVEN8,   // enable 1, A0=0, low lane
        LK_ODD8     // enable 1, A0=1, low lane
    } lane_kind_e;

    function automatic lane_kind_e first_part(input logic mode16,
                                              input logic [1:0] be,
                                              input logic addr0);
        logic [1:0] eff;
        eff = (be == 2'b00) ? (addr0 ? 2'b10 : 2'b01) : be;
        unique case (eff)
            2'b01:   return mode16 ? LK_EVEN16 : LK_EVEN8;
            2'b10:   return mode16 ? LK_ODD16  : LK_ODD8;
            default: return mode16 ? LK_WORD   : LK_EVEN8;
        endcase
    endfunction

    function automatic logic needs_odd_part(input logic mode16,
                                            input logic [1:0] be);
        return !mode16 && (be == 2'b11);
    endfunction

endpackage

// File: rtl/pcc16_wait_sync.sv
module pcc16_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n_async,
    output logic wait_active
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= !wait_n_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign wait_active = chain_q[STAGES-1];
endmodule

// File: rtl/pcc16_lane_map.sv
module pcc16_lane_map
    import pcc16_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  lane_kind_e        kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] rdata_prev,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              a0,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] rdata_merged
);
    localparam logic [LANE_W-1:0] LANE_ZERO = '0;

    always_comb begin
        ce1_n        = 1'b1;
        ce2_n        = 1'b1;
        a0           = 1'b0;
        bus_out      = wdata;
        rdata_merged = rdata_prev;
        unique case (kind)
            LK_WORD: begin
                ce1_n        = 1'b0;
                ce2_n        = 1'b0;
                rdata_merged = bus_in;
            end
            LK_EVEN16: begin
                ce1_n        = 1'b0;
                rdata_merged = {rdata_prev[DATA_W-1:LANE_W], bus_in[LANE_W-1:0]};
            end
            LK_ODD16: begin
                ce2_n        = 1'b0;
                a0           = 1'b1;
                rdata_merged = {bus_in[DATA_W-1:LANE_W], rdata_prev[LANE_W-1:0]};
            end
            LK_EVEN8: begin
                ce1_n        = 1'b0;
                bus_out      = {LANE_ZERO, wdata[LANE_W-1:0]};
                rdata_merged = {rdata_prev[DATA_W-1:LANE_W], bus_in[LANE_W-1:0]};
            end
            LK_ODD8: begin
                ce1_n        = 1'b0;
                a0           = 1'b1;
                bus_out      = {LANE_ZERO, wdata[DATA_W-1:LANE_W]};
                rdata_merged = {bus_in[LANE_W-1:0], rdata_prev[LANE_W-1:0]};
            end
            default: begin
                ce1_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pcc16_cycle_fsm.sv
module pcc16_cycle_fsm
    import pcc16_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_attr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_bus16,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_cmd,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              iois16_n,
    input  logic              wait_active,
    input  logic [DATA_W-1:0] rd_merged,
    output phase_e            phase_o,
    output lane_kind_e        kind_o,
    output logic              write_o,
    output logic              io_o,
    output logic              attr_o,
    output logic              mode16_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e            phase;
        lane_kind_e        kind;
        logic              odd_pending;
        logic              write;
        logic              io;
        logic              attr;
        logic              mode16;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  setup_len;
        logic [CNT_W-1:0]  cmd_len;
        logic [CNT_W-1:0]  hold_len;
    } fsm_t;

    fsm_t st_d, st_q;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase       = PH_SETUP;
                    st_d.write       = req_write;
                    st_d.io          = req_io;
                    st_d.attr        = req_attr;
                    st_d.mode16      = cfg_bus16;
                    st_d.addr        = req_addr;
                    st_d.wdata       = req_wdata;
                    st_d.rdata       = '0;
                    st_d.kind        = first_part(cfg_bus16, req_be, req_addr[0]);
                    st_d.odd_pending = needs_odd_part(cfg_bus16, req_be);
                    st_d.setup_len   = at_least_one(cfg_setup);
                    st_d.cmd_len     = at_least_one(cfg_cmd);
                    st_d.hold_len    = at_least_one(cfg_hold);
                    st_d.cnt         = at_least_one(cfg_setup) - ONE;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    if (st_q.io && st_q.kind == LK_WORD && iois16_n) begin
                        st_d.kind        = LK_EVEN8;
                        st_d.odd_pending = 1'b1;
                    end
                    st_d.phase = PH_CMD;
                    st_d.cnt   = st_q.cmd_len - ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_CMD: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE;
                end else if (!wait_active) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = st_q.hold_len - ONE;
                    if (!st_q.write) st_d.rdata = rd_merged;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - ONE;
                end else if (st_q.odd_pending) begin
                    st_d.odd_pending = 1'b0;
                    st_d.kind        = LK_ODD8;
                    st_d.phase       = PH_SETUP;
                    st_d.cnt         = st_q.setup_len - ONE;
                end else begin
                    st_d.phase = PH_DONE;
                end
            end
            PH_DONE: st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.kind  <= LK_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign kind_o   = st_q.kind;
    assign write_o  = st_q.write;
    assign io_o     = st_q.io;
    assign attr_o   = st_q.attr;
    assign mode16_o = st_q.mode16;
    assign addr_o   = st_q.addr;
    assign wdata_o  = st_q.wdata;
    assign rdata_o  = st_q.rdata;

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CMD && st_q.cnt == '0 && wait_active) |=> (st_q.phase == PH_CMD)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DONE) |=> (st_q.phase == PH_IDLE)); // R10
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |=> ($stable(st_q.addr) && $stable(st_q.write))); // R12
    AST_SPLIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == LK_ODD8 && st_q.phase != PH_IDLE) |-> !st_q.odd_pending); // R9
endmodule

// File: rtl/pcc16_cycle_gen.sv
module pcc16_cycle_gen
    import pcc16_pkg::*;
#(
    parameter int ADDR_W      = 26,
    parameter int LANE_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_attr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_bus16,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_cmd,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              card_wait_n,
    input  logic              card_iois16_n,
    input  logic [DATA_W-1:0] card_data_in,
    output logic              card_ce1_n,
    output logic              card_ce2_n,
    output logic              card_reg_n,
    output logic              card_oe_n,
    output logic              card_we_n,
    output logic              card_iord_n,
    output logic              card_iowr_n,
    output logic [ADDR_W-1:0] card_addr,
    output logic [DATA_W-1:0] card_data_out,
    output logic              card_data_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic              wait_active;
    phase_e            phase;
    lane_kind_e        kind;
    logic              acc_write, acc_io, acc_attr, acc_mode16;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata, acc_rdata, rd_merged, lane_out;
    logic              map_ce1_n, map_ce2_n, map_a0;
    logic              in_access, in_cmd;

    pcc16_wait_sync #(.STAGES(SYNC_STAGES)) i_wait_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_n_async (card_wait_n),
        .wait_active  (wait_active)
    );

    pcc16_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_io      (req_io),
        .req_attr    (req_attr),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .cfg_bus16   (cfg_bus16),
        .cfg_setup   (cfg_setup),
        .cfg_cmd     (cfg_cmd),
        .cfg_hold    (cfg_hold),
        .iois16_n    (card_iois16_n),
        .wait_active (wait_active),
        .rd_merged   (rd_merged),
        .phase_o     (phase),
        .kind_o      (kind),
        .write_o     (acc_write),
        .io_o        (acc_io),
        .attr_o      (acc_attr),
        .mode16_o    (acc_mode16),
        .addr_o      (acc_addr),
        .wdata_o     (acc_wdata),
        .rdata_o     (acc_rdata)
    );

    pcc16_lane_map #(.LANE_W(LANE_W)) i_lane_map (
        .kind         (kind),
        .wdata        (acc_wdata),
        .bus_in       (card_data_in),
        .rdata_prev   (acc_rdata),
        .ce1_n        (map_ce1_n),
        .ce2_n        (map_ce2_n),
        .a0           (map_a0),
        .bus_out      (lane_out),
        .rdata_merged (rd_merged)
    );

    always_comb begin
        in_access     = (phase == PH_SETUP) || (phase == PH_CMD) || (phase == PH_HOLD);
        in_cmd        = (phase == PH_CMD);
        card_ce1_n    = in_access ? map_ce1_n : 1'b1;
        card_ce2_n    = in_access ? map_ce2_n : 1'b1;
        card_reg_n    = in_access ? (acc_io ? 1'b0 : !acc_attr) : 1'b1;
        card_oe_n     = !(in_cmd && !acc_io && !acc_write);
        card_we_n     = !(in_cmd && !acc_io &&  acc_write);
        card_iord_n   = !(in_cmd &&  acc_io && !acc_write);
        card_iowr_n   = !(in_cmd &&  acc_io &&  acc_write);
        card_addr     = in_access ? {acc_addr[ADDR_W-1:1], map_a0} : '0;
        card_data_oe  = in_access && acc_write;
        card_data_out = card_data_oe ? lane_out : '0;
        busy          = (phase != PH_IDLE);
        done          = (phase == PH_DONE);
        rdata         = acc_rdata;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (card_ce1_n && card_ce2_n && card_reg_n && card_oe_n && card_we_n
                   && card_iord_n && card_iowr_n && !card_data_oe)); // R1
    AST_IO_REG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_iord_n || !card_iowr_n) |-> !card_reg_n); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n})); // R3
    AST_STROBE_HAS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n) |-> (!card_ce1_n || !card_ce2_n)); // R5
    AST_CE2_QUIET_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !acc_mode16) |-> card_ce2_n); // R6
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_oe_n || !card_iord_n) |-> !card_data_oe); // R11
    AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP) |=> (card_oe_n && card_we_n && card_iord_n && card_iowr_n)
                                || (phase == PH_CMD)); // R7
endmodule

// File: tb/test_pcc16_cycle_gen.sv
module test_pcc16_cycle_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_attr = 1'b0;
    logic [25:0] req_addr = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        cfg_bus16 = 1'b1;
    logic [3:0]  cfg_setup = 4'd2, cfg_cmd = 4'd6, cfg_hold = 4'd2;
    logic        card_wait_n = 1'b1, card_iois16_n = 1'b0;
    logic [15:0] card_data_in = '0;
    logic        card_ce1_n, card_ce2_n, card_reg_n, card_oe_n, card_we_n;
    logic        card_iord_n, card_iowr_n, card_data_oe, busy, done;
    logic [25:0] card_addr;
    logic [15:0] card_data_out, rdata;

    pcc16_cycle_gen i_pcc16_cycle_gen (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0, errors = 0, cycles = 0;
    bit    finished = 0;
    string sc = "reset";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, sc, what, act, exp);
        end
    endtask

    // Behavioural model: phase 0 idle, 1 setup, 2 command, 3 hold, 4 done.
    // kind 0 word, 1 even16, 2 odd16, 3 even8, 4 odd8.
    int          m_phase = 0, m_rem = 0, m_kind = 0, m_s = 1, m_c = 1, m_h = 1;
    bit          m_odd = 0, m_wr = 0, m_io = 0, m_attr = 0, m_m16 = 1, ws1 = 0, ws2 = 0;
    logic [25:0] m_addr = '0;
    logic [15:0] m_wd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; ws1 = 0; ws2 = 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    logic [1:0] be;
                    be = req_be;
                    if (be == 2'b00) be = req_addr[0] ? 2'b10 : 2'b01;
                    m_wr = req_write; m_io = req_io; m_attr = req_attr; m_m16 = cfg_bus16;
                    m_addr = req_addr; m_wd = req_wdata;
                    m_s = (cfg_setup == 0) ? 1 : int'(cfg_setup);
                    m_c = (cfg_cmd == 0) ? 1 : int'(cfg_cmd);
                    m_h = (cfg_hold == 0) ? 1 : int'(cfg_hold);
                    if (cfg_bus16) begin
                        m_kind = (be == 2'b11) ? 0 : (be == 2'b01) ? 1 : 2;
                        m_odd = 0;
                    end else begin
                        m_kind = (be == 2'b10) ? 4 : 3;
                        m_odd = (be == 2'b11);
                    end
                    m_phase = 1; m_rem = m_s - 1;
                end
                1: if (m_rem == 0) begin
                    if (m_io && m_kind == 0 && card_iois16_n) begin m_kind = 3; m_odd = 1; end
                    m_phase = 2; m_rem = m_c - 1;
                end else m_rem--;
                2: if (m_rem > 0) m_rem--;
                   else if (!ws2) begin m_phase = 3; m_rem = m_h - 1; end
                3: if (m_rem > 0) m_rem--;
                   else if (m_odd) begin m_odd = 0; m_kind = 4; m_phase = 1; m_rem = m_s - 1; end
                   else m_phase = 4;
                default: m_phase = 0;
            endcase
            ws2 = ws1;
            ws1 = !card_wait_n;
        end
    end

    // Compare every clock, half a period after the edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit act, cmd;
            bit e_ce1, e_ce2, e_a0, e_reg;
            logic [15:0] e_dout;
            string ce_tag;
            act = (m_phase >= 1 && m_phase <= 3);
            cmd = (m_phase == 2);
            e_ce1 = !(act && m_kind != 2);
            e_ce2 = !(act && (m_kind == 0 || m_kind == 2));
            e_a0  = (m_kind == 2 || m_kind == 4);
            e_reg = act ? (m_io ? 1'b0 : !m_attr) : 1'b1;
            e_dout = (!(act && m_wr)) ? 16'h0 : (m_kind == 3) ? {8'h0, m_wd[7:0]}
                   : (m_kind == 4) ? {8'h0, m_wd[15:8]} : m_wd;
            ce_tag = m_m16 ? "R5" : "R6";
            chk(busy == (m_phase != 0), "R1", "busy", busy, m_phase != 0);
            chk(card_reg_n == e_reg, "R2", "reg_n", card_reg_n, e_reg);
            chk({card_oe_n, card_we_n} == {!(cmd && !m_io && !m_wr), !(cmd && !m_io && m_wr)},
                "R3", "oe_n/we_n", {card_oe_n, card_we_n},
                {!(cmd && !m_io && !m_wr), !(cmd && !m_io && m_wr)});
            chk({card_iord_n, card_iowr_n} == {!(cmd && m_io && !m_wr), !(cmd && m_io && m_wr)},
                "R4", "iord_n/iowr_n", {card_iord_n, card_iowr_n},
                {!(cmd && m_io && !m_wr), !(cmd && m_io && m_wr)});
            chk({card_ce1_n, card_ce2_n} == {e_ce1, e_ce2}, ce_tag, "ce1_n/ce2_n",
                {card_ce1_n, card_ce2_n}, {e_ce1, e_ce2});
            chk(card_addr == (act ? {m_addr[25:1], e_a0} : 26'h0), ce_tag, "addr",
                card_addr, act ? {m_addr[25:1], e_a0} : 26'h0);
            chk(card_data_oe == (act && m_wr) && card_data_out == e_dout, "R11", "data_out",
                {card_data_oe, card_data_out}, {act && m_wr, e_dout});
            chk(done == (m_phase == 4), "R10", "done", done, m_phase == 4);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_req(input string tag, input bit wr, input bit io, input bit attr,
                           input logic [25:0] a, input logic [1:0] be, input logic [15:0] wd,
                           input logic [15:0] din, input bit m16,
                           input logic [3:0] s, input logic [3:0] c, input logic [3:0] h,
                           input bit iois_n, input int wait_clks, input bit poke,
                           input int base_cycles, input logic [15:0] exp_rd);
        int n;
        @(negedge clk);
        sc = tag;
        req_write = wr; req_io = io; req_attr = attr; req_addr = a; req_be = be;
        req_wdata = wd; card_data_in = din; cfg_bus16 = m16;
        cfg_setup = s; cfg_cmd = c; cfg_hold = h; card_iois16_n = iois_n;
        card_wait_n = (wait_clks > 0) ? 1'b0 : 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        for (int k = 1; k < 1000; k++) begin
            if (k == wait_clks) card_wait_n = 1'b1;
            if (poke && k == 2) begin req_valid = 1'b1; req_addr = ~a; req_write = !wr; end
            if (poke && k == 3) req_valid = 1'b0;
            if (done) break;
            @(negedge clk);
            n++;
        end
        if (wait_clks > 0)
            chk(n > base_cycles, "R8", "busy length with wait", n, base_cycles + 1);
        else
            chk(n == base_cycles, "R7", "busy length", n, base_cycles);
        if (!wr) chk(rdata == exp_rd, "R10", "rdata", rdata, exp_rd);
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after done", {busy, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && card_ce1_n && card_ce2_n && card_reg_n && card_oe_n && card_iord_n
            && !card_data_oe, "R1", "reset state", {busy, card_ce1_n, card_oe_n}, 3'b011);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // tag, wr, io, attr, addr, be, wdata, din, m16, s, c, h, iois_n, wait, poke, cycles, rdata
        run_req("R3 mem word read",   0, 0, 0, 26'h0001234, 2'b11, 16'h0,    16'hA55A, 1, 2, 6, 2, 0, 0,  0, 11, 16'hA55A);
        run_req("R2 attr even write", 1, 0, 1, 26'h0000200, 2'b01, 16'h5AC3, 16'h0,    1, 2, 6, 2, 0, 0,  0, 11, 16'h0);
        run_req("R5 odd byte read",   0, 0, 0, 26'h0000401, 2'b10, 16'h0,    16'h12C3, 1, 2, 6, 2, 0, 0,  0, 11, 16'h1200);
        run_req("R4 io word write",   1, 1, 0, 26'h00003F8, 2'b11, 16'hBEEF, 16'h0,    1, 2, 6, 2, 0, 0,  0, 11, 16'h0);
        run_req("R9 io 8-bit port",   0, 1, 0, 26'h0000300, 2'b11, 16'h0,    16'h3C7E, 1, 2, 6, 2, 1, 0,  0, 21, 16'h7E7E);
        run_req("R6 8-bit word write",1, 0, 0, 26'h0000010, 2'b11, 16'hC0DE, 16'h0,    0, 2, 6, 2, 0, 0,  0, 21, 16'h0);
        run_req("R6 8-bit odd read",  0, 0, 1, 26'h0000021, 2'b10, 16'h0,    16'h00B4, 0, 1, 3, 1, 0, 0,  0, 6,  16'hB400);
        run_req("R8 wait stretch",    0, 0, 0, 26'h0000800, 2'b11, 16'h0,    16'hF00F, 1, 2, 6, 2, 0, 12, 0, 11, 16'hF00F);
        run_req("R7 zero counts",     1, 0, 0, 26'h0000042, 2'b11, 16'h1357, 16'h0,    1, 0, 0, 0, 0, 0,  0, 4,  16'h0);
        run_req("R7 uneven counts",   0, 1, 0, 26'h0000060, 2'b01, 16'h0,    16'h6699, 1, 1, 3, 4, 0, 0,  0, 9,  16'h0099);
        run_req("R13 be zero odd",    0, 0, 0, 26'h0000103, 2'b00, 16'h0,    16'h9A5B, 1, 2, 6, 2, 0, 0,  0, 11, 16'h9A00);
        run_req("R13 be zero 8-bit",  1, 1, 0, 26'h0000104, 2'b00, 16'h77E1, 16'h0,    0, 2, 2, 2, 0, 0,  0, 7,  16'h0);
        run_req("R12 busy ignore",    1, 0, 0, 26'h0000500, 2'b11, 16'h2468, 16'h0,    1, 2, 6, 2, 0, 0,  1, 11, 16'h0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule